// File: doc/BRIEF.md
# Read-Sequence Write-Protect Detector

This block keeps the software write-protect state of a flash memory device. It watches a stream of read cycles, each given as a one-cycle strobe together with the address latched for that read. Two patterns of seven consecutive reads change the state. The first six addresses are the same in both patterns: 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h. A seventh read at 041Ah removes protection. A seventh read at 040Ah restores it. The data returned by those reads plays no part.

The single output is a protect flag that the command logic uses to refuse erase and program operations. The flag is set at power-on reset. Any write cycle throws away a partial match, so a command written in the middle of an attempt spoils that attempt. No write, including a reset command, ever changes the flag. Pin-level edge detection and command decoding belong to neighbouring logic and are not part of this block.

Top module: `wp_seq_detect`

## Requirements
- R1: After power-on reset is released, `wp_protected` is 1.
- R2: Seven consecutive read strobes at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 041Ah clear `wp_protected` to 0, visible in the clock cycle after the seventh strobe.
- R3: Seven consecutive read strobes at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 040Ah set `wp_protected` to 1, visible in the clock cycle after the seventh strobe.
- R4: `wp_protected` changes only in the cycle after a seventh matching read; incomplete patterns leave it unchanged.
- R5: A read whose address differs from the next expected one discards the match in progress; if that address is 1823h, it counts as the first step of a new attempt.
- R6: A write strobe discards any match in progress and never changes `wp_protected`.
- R7: While `rd_stb` is 0, `rd_addr` is ignored and the match in progress is kept.
- R8: When `wr_stb` and `rd_stb` are both 1 in the same cycle, the write takes priority and the read is disregarded.
- R9: Addresses are compared on all 19 bits; an address that agrees with a pattern address only in the low bits does not match.
- R10: Completing a pattern that leaves the flag at the value it already holds causes no change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rd_stb | input | 1 | One-cycle pulse per completed read cycle |
| rd_addr | input | 19 | Latched address of the read carried by `rd_stb` |
| wr_stb | input | 1 | One-cycle pulse per write cycle |
| wp_protected | output | 1 | 1 while erase and program are blocked |

## Verification
The assertions assume that `rd_stb` and `wr_stb` are stable for whole clock cycles and that each strobe stands for exactly one bus cycle. They also assume the inputs stay idle until the internal reset has been released. The stimulus drives all inputs on the falling clock edge and holds them low through reset. Random cycles weight the address choice toward the next expected pattern address, so complete, broken and restarted patterns all appear. Directed cases add simultaneous read and write, near-miss upper address bits, and idle gaps that carry junk addresses.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  parameter int unsigned WP_ADDR_W  = 19;
  parameter int unsigned WP_SEQ_LEN = 7;

  localparam int unsigned WP_STEP_W = $clog2(WP_SEQ_LEN);
  localparam int unsigned WP_LAST   = WP_SEQ_LEN - 1;

  typedef logic [WP_ADDR_W-1:0] wp_addr_t;
  typedef logic [WP_STEP_W-1:0] wp_step_t;

  // Final-step alternatives: they decide the direction of the flag change.
  localparam wp_addr_t WP_UNLOCK_TAIL = wp_addr_t'(16'h041A);
  localparam wp_addr_t WP_LOCK_TAIL   = wp_addr_t'(16'h040A);

  // Shared prefix addresses, in the order they must be read.
  function automatic wp_addr_t wp_step_addr(input int unsigned idx);
    wp_addr_t a;
    case (idx)
      0:       a = wp_addr_t'(16'h1823);
      1:       a = wp_addr_t'(16'h1820);
      2:       a = wp_addr_t'(16'h1822);
      3:       a = wp_addr_t'(16'h0418);
      4:       a = wp_addr_t'(16'h041B);
      5:       a = wp_addr_t'(16'h0419);
      default: a = '1;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wp_addr_match.sv
module wp_addr_match
  import wp_seq_pkg::*;
(
  input  wp_step_t step,
  input  wp_addr_t addr,
  output logic     hit_next,
  output logic     hit_head,
  output logic     hit_unlock,
  output logic     hit_lock
);

  logic [WP_SEQ_LEN-1:0] step_hit;

  // One comparator per prefix position; the last slot never matches here.
  for (genvar g = 0; g < WP_SEQ_LEN; g++) begin : g_cmp
    if (g < WP_LAST) begin : g_prefix
      assign step_hit[g] = (addr == wp_step_addr(g));
    end else begin : g_tail
      assign step_hit[g] = 1'b0;
    end
  end

  assign hit_next   = step_hit[step];
  assign hit_head   = step_hit[0];
  assign hit_unlock = (addr == WP_UNLOCK_TAIL);
  assign hit_lock   = (addr == WP_LOCK_TAIL);

endmodule

// File: rtl/wp_step_ctrl.sv
module wp_step_ctrl
  import wp_seq_pkg::*;
(
  input  logic     clk,
  input  logic     srst_n,
  input  logic     rd_stb,
  input  logic     wr_stb,
  input  logic     hit_next,
  input  logic     hit_head,
  input  logic     hit_unlock,
  input  logic     hit_lock,
  output wp_step_t step_q,
  output logic     seq_done,
  output logic     lock_req
);

  localparam wp_step_t LAST_STEP = wp_step_t'(WP_LAST);
  localparam wp_step_t HEAD_NEXT = wp_step_t'(1);

  wp_step_t step_d;
  logic     step_en;
  logic     rd_take;
  logic     at_last;

  assign rd_take = rd_stb && !wr_stb;
  assign at_last = (step_q == LAST_STEP);
  assign step_en = rd_stb || wr_stb;

  always_comb begin
    step_d = step_q;
    if (wr_stb) begin
      step_d = '0;
    end else if (rd_stb) begin
      if (!at_last && hit_next) begin
        step_d = step_q + HEAD_NEXT;
      end else if (hit_head) begin
        step_d = HEAD_NEXT;
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  assign seq_done = rd_take && at_last && (hit_unlock || hit_lock);
  assign lock_req = hit_lock;

endmodule

// File: rtl/wp_flag_reg.sv
module wp_flag_reg (
  input  logic clk,
  input  logic srst_n,
  input  logic seq_done,
  input  logic lock_req,
  output logic prot_q
);

  logic prot_d;

  always_comb begin
    prot_d = prot_q;
    if (seq_done) begin
      prot_d = lock_req;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prot_q <= 1'b1;
    end else if (seq_done) begin
      prot_q <= prot_d;
    end
  end

endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
  import wp_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_stb,
  input  logic [WP_ADDR_W-1:0] rd_addr,
  input  logic                 wr_stb,
  output logic                 wp_protected
);

  logic     srst_n;
  wp_step_t step_q;
  logic     hit_next;
  logic     hit_head;
  logic     hit_unlock;
  logic     hit_lock;
  logic     seq_done;
  logic     lock_req;

  wp_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  wp_addr_match i_addr_match (
    .step       (step_q),
    .addr       (rd_addr),
    .hit_next   (hit_next),
    .hit_head   (hit_head),
    .hit_unlock (hit_unlock),
    .hit_lock   (hit_lock)
  );

  wp_step_ctrl i_step_ctrl (
    .clk        (clk),
    .srst_n     (srst_n),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .hit_next   (hit_next),
    .hit_head   (hit_head),
    .hit_unlock (hit_unlock),
    .hit_lock   (hit_lock),
    .step_q     (step_q),
    .seq_done   (seq_done),
    .lock_req   (lock_req)
  );

  wp_flag_reg i_flag_reg (
    .clk      (clk),
    .srst_n   (srst_n),
    .seq_done (seq_done),
    .lock_req (lock_req),
    .prot_q   (wp_protected)
  );

endmodule

// File: rtl/wp_seq_detect_chk.sv
module wp_seq_detect_chk
  import wp_seq_pkg::*;
(
  input logic     clk,
  input logic     srst_n,
  input logic     rd_stb,
  input logic     wr_stb,
  input wp_addr_t rd_addr,
  input wp_step_t step,
  input logic     prot
);

  localparam wp_step_t LAST_STEP = wp_step_t'(WP_LAST);

  assert_step_range_R5: assert property (@(posedge clk) disable iff (!srst_n)
    step <= LAST_STEP);

  assert_change_on_final_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !$stable(prot) |-> ($past(rd_stb) && !$past(wr_stb) && $past(step) == LAST_STEP));

  assert_unlock_tail_R2: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(prot) |-> $past(rd_addr) == WP_UNLOCK_TAIL);

  assert_lock_tail_R3: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(prot) |-> $past(rd_addr) == WP_LOCK_TAIL);

  assert_write_abort_R6: assert property (@(posedge clk) disable iff (!srst_n)
    wr_stb |=> (step == '0 && prot == $past(prot)));

  assert_mismatch_restart_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_stb && !wr_stb && step != LAST_STEP && rd_addr != wp_step_addr(int'(step)))
      |=> step <= wp_step_t'(1));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (!rd_stb && !wr_stb) |=> ($stable(step) && $stable(prot)));

endmodule

bind wp_seq_detect wp_seq_detect_chk i_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .rd_stb  (rd_stb),
  .wr_stb  (wr_stb),
  .rd_addr (rd_addr),
  .step    (step_q),
  .prot    (wp_protected)
);

// File: tb/test_wp_seq_detect.sv
module test_wp_seq_detect;

  logic        clk;
  logic        rst_n;
  logic        rd_stb;
  logic [18:0] rd_addr;
  logic        wr_stb;
  logic        wp_protected;

  int tests;
  int fails;
  int cycles;
  bit done;

  // Bench copy of the patterns, written from the requirements.
  logic [18:0] pat [0:5] = '{19'h01823, 19'h01820, 19'h01822,
                             19'h00418, 19'h0041B, 19'h00419};
  localparam logic [18:0] TAIL_OPEN = 19'h0041A;
  localparam logic [18:0] TAIL_SHUT = 19'h0040A;

  int m_step;
  bit m_prot;

  wp_seq_detect i_wp_seq_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_stb       (rd_stb),
    .rd_addr      (rd_addr),
    .wr_stb       (wr_stb),
    .wp_protected (wp_protected)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit exp, input string req);
    tests++;
    if (wp_protected !== exp) begin
      fails++;
      $display("FAIL %s: wp_protected=%0b expected=%0b", req, wp_protected, exp);
    end
  endtask

  task automatic model(input bit rd, input bit wr, input logic [18:0] a);
    if (wr) begin
      m_step = 0;
    end else if (rd) begin
      if (m_step == 6) begin
        if (a == TAIL_OPEN) m_prot = 1'b0;
        else if (a == TAIL_SHUT) m_prot = 1'b1;
        m_step = (a == pat[0]) ? 1 : 0;
      end else if (a == pat[m_step]) begin
        m_step = m_step + 1;
      end else begin
        m_step = (a == pat[0]) ? 1 : 0;
      end
    end
  endtask

  // Drive one cycle at a falling edge, check at the next falling edge.
  task automatic cyc(input bit rd, input bit wr, input logic [18:0] a, input string req);
    rd_stb  = rd;
    wr_stb  = wr;
    rd_addr = a;
    @(negedge clk);
    model(rd, wr, a);
    check(m_prot, req);
    rd_stb = 1'b0;
    wr_stb = 1'b0;
  endtask

  task automatic prefix(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, pat[i], req);
  endtask

  initial begin
    int unsigned r;
    logic [18:0] a;
    tests = 0; fails = 0; cycles = 0; done = 0;
    m_step = 0; m_prot = 1'b1;
    rst_n = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; rd_addr = '0;
    void'($urandom(32'd1187));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1'b1, "R1 reset state");

    // R4: partial pattern leaves protection on
    prefix(6, "R4 partial");
    cyc(1'b0, 1'b0, 19'h0, "R4 idle after partial");
    cyc(1'b1, 1'b0, 19'h00011, "R4 wrong tail");
    check(1'b1, "R4 still protected");

    // R2: full unlock
    prefix(6, "R2 prefix");
    cyc(1'b1, 1'b0, TAIL_OPEN, "R2 unlock tail");
    check(1'b0, "R2 unprotected");

    // R10: unlock again keeps 0
    prefix(6, "R10 prefix");
    cyc(1'b1, 1'b0, TAIL_OPEN, "R10 repeat unlock");
    check(1'b0, "R10 still unprotected");

    // R3: lock
    prefix(6, "R3 prefix");
    cyc(1'b1, 1'b0, TAIL_SHUT, "R3 lock tail");
    check(1'b1, "R3 protected");

    // R5: restart on 1823h counts as first step
    cyc(1'b1, 1'b0, pat[0], "R5 start");
    cyc(1'b1, 1'b0, pat[1], "R5 second");
    cyc(1'b1, 1'b0, pat[0], "R5 restart");
    for (int i = 1; i < 6; i++) cyc(1'b1, 1'b0, pat[i], "R5 continue");
    cyc(1'b1, 1'b0, TAIL_OPEN, "R5 tail");
    check(1'b0, "R5 restart counted");

    // R5: mismatch mid-pattern discards progress
    prefix(3, "R5 mismatch prefix");
    cyc(1'b1, 1'b0, 19'h00418 ^ 19'h1, "R5 mismatch");
    for (int i = 3; i < 6; i++) cyc(1'b1, 1'b0, pat[i], "R5 after mismatch");
    cyc(1'b1, 1'b0, TAIL_SHUT, "R5 orphan tail");
    check(1'b0, "R5 no lock after mismatch");

    // R6: write in the middle aborts, write alone changes nothing
    prefix(4, "R6 prefix");
    cyc(1'b0, 1'b1, 19'h00000, "R6 write abort");
    for (int i = 4; i < 6; i++) cyc(1'b1, 1'b0, pat[i], "R6 after write");
    cyc(1'b1, 1'b0, TAIL_SHUT, "R6 orphan tail");
    check(1'b0, "R6 abort held");
    cyc(1'b0, 1'b1, 19'h000FF, "R6 reset command");
    check(1'b0, "R6 write leaves flag");

    // R7: idle cycles with junk addresses do not disturb a pattern
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b0, pat[i], "R7 read");
      cyc(1'b0, 1'b0, 19'h7FFFF, "R7 idle junk");
    end
    cyc(1'b1, 1'b0, TAIL_SHUT, "R7 tail");
    check(1'b1, "R7 locked through gaps");

    // R8: simultaneous read and write on the final step
    prefix(6, "R8 prefix");
    cyc(1'b1, 1'b1, TAIL_OPEN, "R8 collide");
    check(1'b1, "R8 write wins");

    // R9: upper address bit set does not match
    cyc(1'b1, 1'b0, 19'h41823, "R9 high bit");
    for (int i = 1; i < 6; i++) cyc(1'b1, 1'b0, pat[i], "R9 rest");
    cyc(1'b1, 1'b0, TAIL_OPEN, "R9 tail");
    check(1'b1, "R9 full-width compare");

    // Random mix, steered toward the next expected address
    for (int n = 0; n < 4000; n++) begin
      r = $urandom_range(0, 99);
      if (r < 70) begin
        if (m_step == 6) a = ($urandom_range(0, 1) == 1) ? TAIL_OPEN : TAIL_SHUT;
        else a = pat[m_step];
      end else if (r < 80) begin
        a = pat[$urandom_range(0, 5)];
      end else begin
        a = 19'($urandom);
      end
      r = $urandom_range(0, 99);
      cyc(r < 75, (r % 19) == 0, a, "R4 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule